// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional-trap instruction fires. It takes two operands and a 5-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. When at least one enabled relation holds, the block raises a trap request. The request carries a cause code that tells the exception logic the program exception came from a trap.

The operands are `DATA_W` bits wide, 64 by default. A per-request mode input chooses between two compares. The doubleword compare uses the full operands. The word compare uses only the low `WORD_W` bits, 32 by default, and takes the sign from bit `WORD_W-1`. Instruction decode and exception entry sit around the block and are not part of it. The result is registered and appears one clock after the input strobe.

Top module: `trap_compare_unit`

## Requirements
- R1: Mask bit 4 (value 5'h10) enables a trap when operand A is less than operand B as signed numbers.
- R2: Mask bit 3 (value 5'h08) enables a trap when operand A is greater than operand B as signed numbers.
- R3: Mask bit 2 (value 5'h04) enables a trap when the compared operands are equal.
- R4: Mask bit 1 (value 5'h02) enables a trap when operand A is less than operand B as unsigned numbers.
- R5: Mask bit 0 (value 5'h01) enables a trap when operand A is greater than operand B as unsigned numbers.
- R6: The trap request is the OR of all enabled relations. If every enabled relation is false, there is no trap, even when a relation that is not enabled is true.
- R7: With `dword_mode` = 0, only bits [WORD_W-1:0] of each operand are compared, and the sign is taken from bit WORD_W-1. Differences in the upper bits have no effect on the result.
- R8: With `dword_mode` = 1, all DATA_W bits are compared, and the sign is taken from bit DATA_W-1.
- R9: A mask of 5'h00 never raises a trap.
- R10: A mask of 5'h1F always raises a trap, whatever the operand values.
- R11: `out_valid` and `trap_req` are registered. They show the result of a request in the clock after `in_valid` was high. With `in_valid` low, the next cycle has `out_valid` = 0 and `trap_req` = 0.
- R12: `trap_cause` equals 4'h2 (program exception, trap) whenever `trap_req` is 1, and equals 4'h0 otherwise.
- R13: A synchronous active-high `rst` clears `out_valid`, `trap_req` and `trap_cause` at the next clock edge, even when `in_valid` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one evaluation per high cycle |
| dword_mode | input | 1 | 1 = full-width compare, 0 = low-word compare |
| cond_mask | input | 5 | Relation enables (bit 4 s-lt, bit 3 s-gt, bit 2 eq, bit 1 u-lt, bit 0 u-gt) |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| trap_req | output | 1 | Trap raised for the request |
| trap_cause | output | 4 | Exception cause code, 4'h2 when trap_req is 1, else 0 |

## Verification
The bench uses operands where the signed and unsigned orderings disagree, such as all-ones against one. A design that swapped the signed and unsigned relations, or the two directions of one relation, gives the wrong answer on those vectors.

Word-mode vectors put bit 31 set under a clear bit 63, and put unequal upper halves over equal low words. A design that compared full width in word mode, or took the sign from the wrong bit, reverses those results.

The empty mask, the full mask, and masks that enable every relation except the one that holds catch a design that ignores the enables or ANDs the relations together. The reset-during-request and idle-cycle tests catch outputs that are not registered, or that stay high for more than one cycle.

// File: rtl/trap_compare_pkg.sv
package trap_compare_pkg;
  // Mask bit positions (bit order is part of the instruction encoding)
  localparam int REL_N      = 5;
  localparam int BIT_SLT    = 4;
  localparam int BIT_SGT    = 3;
  localparam int BIT_EQ     = 2;
  localparam int BIT_ULT    = 1;
  localparam int BIT_UGT    = 0;

  localparam int CAUSE_W    = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

  typedef logic [REL_N-1:0] rel_vec_t;
endpackage

// File: rtl/trap_operand_prep.sv
// Forms the signed-view and unsigned-view operands for the chosen compare width.
module trap_operand_prep #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              dword_mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] sgn_a,
  output logic [DATA_W-1:0] sgn_b,
  output logic [DATA_W-1:0] usg_a,
  output logic [DATA_W-1:0] usg_b
);
  localparam int EXT_W = DATA_W - WORD_W;

  generate
    if (EXT_W > 0) begin : g_narrow
      logic [WORD_W-1:0] lo_a, lo_b;
      assign lo_a  = op_a[WORD_W-1:0];
      assign lo_b  = op_b[WORD_W-1:0];
      assign sgn_a = dword_mode ? op_a : {{EXT_W{lo_a[WORD_W-1]}}, lo_a};
      assign sgn_b = dword_mode ? op_b : {{EXT_W{lo_b[WORD_W-1]}}, lo_b};
      assign usg_a = dword_mode ? op_a : {{EXT_W{1'b0}}, lo_a};
      assign usg_b = dword_mode ? op_b : {{EXT_W{1'b0}}, lo_b};
    end else begin : g_same
      // Both widths coincide: the mode select degenerates to a pass-through.
      assign sgn_a = dword_mode ? op_a : op_a;
      assign sgn_b = dword_mode ? op_b : op_b;
      assign usg_a = op_a;
      assign usg_b = op_b;
    end
  endgenerate
endmodule

// File: rtl/trap_relation_eval.sv
// Evaluates the five operand relations in parallel.
module trap_relation_eval
  import trap_compare_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] sgn_a,
  input  logic [DATA_W-1:0] sgn_b,
  input  logic [DATA_W-1:0] usg_a,
  input  logic [DATA_W-1:0] usg_b,
  output rel_vec_t          rel
);
  always_comb begin
    rel          = '0;
    rel[BIT_SLT] = $signed(sgn_a) < $signed(sgn_b);
    rel[BIT_SGT] = $signed(sgn_a) > $signed(sgn_b);
    rel[BIT_EQ]  = (usg_a == usg_b);
    rel[BIT_ULT] = usg_a < usg_b;
    rel[BIT_UGT] = usg_a > usg_b;
  end
endmodule

// File: rtl/trap_mask_reduce.sv
// Gates each relation by its enable and ORs the survivors.
module trap_mask_reduce
  import trap_compare_pkg::*;
(
  input  rel_vec_t rel,
  input  rel_vec_t mask,
  output logic     hit
);
  rel_vec_t gated;

  genvar gi;
  generate
    for (gi = 0; gi < REL_N; gi++) begin : g_gate
      assign gated[gi] = rel[gi] & mask[gi];
    end
  endgenerate

  assign hit = |gated;
endmodule

// File: rtl/trap_compare_unit.sv
module trap_compare_unit
  import trap_compare_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              dword_mode,
  input  logic [4:0]        cond_mask,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic              trap_req,
  output logic [3:0]        trap_cause
);
  logic [DATA_W-1:0] sgn_a, sgn_b, usg_a, usg_b;
  rel_vec_t          rel;
  logic              hit;

  trap_operand_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep (
    .dword_mode (dword_mode),
    .op_a       (op_a),
    .op_b       (op_b),
    .sgn_a      (sgn_a),
    .sgn_b      (sgn_b),
    .usg_a      (usg_a),
    .usg_b      (usg_b)
  );

  trap_relation_eval #(.DATA_W(DATA_W)) u_rel (
    .sgn_a (sgn_a),
    .sgn_b (sgn_b),
    .usg_a (usg_a),
    .usg_b (usg_b),
    .rel   (rel)
  );

  trap_mask_reduce u_red (
    .rel  (rel),
    .mask (cond_mask),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      trap_req   <= 1'b0;
      trap_cause <= CAUSE_NONE;
    end else begin
      out_valid  <= in_valid;
      trap_req   <= in_valid & hit;
      trap_cause <= (in_valid & hit) ? CAUSE_TRAP : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/trap_compare_checker.sv
module trap_compare_checker #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              dword_mode,
  input logic [4:0]        cond_mask,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              out_valid,
  input logic              trap_req,
  input logic [3:0]        trap_cause
);
  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !trap_req));

  // R9
  empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_mask == 5'h00) |=> !trap_req);

  // R10
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_mask == 5'h1F) |=> trap_req);

  // R12
  cause_trap_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_cause == 4'h2));

  // R12
  cause_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> (trap_cause == 4'h0));

  // R3
  eq_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dword_mode && cond_mask == 5'h04 && op_a == op_b) |=> trap_req);

  // R7
  eq_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dword_mode && cond_mask == 5'h04 &&
     op_a[WORD_W-1:0] == op_b[WORD_W-1:0]) |=> trap_req);
endmodule

bind trap_compare_unit trap_compare_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .dword_mode (dword_mode),
  .cond_mask  (cond_mask),
  .op_a       (op_a),
  .op_b       (op_b),
  .out_valid  (out_valid),
  .trap_req   (trap_req),
  .trap_cause (trap_cause)
);

// File: tb/sim_trap_compare_unit.sv
`timescale 1ns/1ps
module sim_trap_compare_unit;
  localparam int DATA_W = 64;
  localparam int VW     = 1 + 5 + DATA_W + DATA_W + 1;
  localparam int NV     = 19;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic              dword_mode;
  logic [4:0]        cond_mask;
  logic [DATA_W-1:0] op_a, op_b;
  logic              out_valid, trap_req;
  logic [3:0]        trap_cause;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trap_compare_unit #(.DATA_W(DATA_W), .WORD_W(32)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dword_mode(dword_mode),
    .cond_mask(cond_mask), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .trap_req(trap_req), .trap_cause(trap_cause)
  );

  // {dword_mode, mask, op_a, op_b, expected trap}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                  // R1 -1 < 1 signed
    {1'b1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                  // R4 not below unsigned
    {1'b1, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                  // R5
    {1'b1, 5'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                  // R2 false
    {1'b1, 5'h04, 64'h5, 64'h5, 1'b1},                                    // R3
    {1'b1, 5'h1B, 64'h5, 64'h5, 1'b0},                                    // R6 only eq holds, eq off
    {1'b1, 5'h08, 64'h7, 64'h3, 1'b1},                                    // R2
    {1'b1, 5'h02, 64'h3, 64'h7, 1'b1},                                    // R4
    {1'b0, 5'h10, 64'h0000_0001_8000_0000, 64'h0, 1'b1},                  // R7 sign at bit 31
    {1'b1, 5'h10, 64'h0000_0001_8000_0000, 64'h0, 1'b0},                  // R8 sign at bit 63
    {1'b0, 5'h04, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 1'b1},// R7 upper ignored
    {1'b1, 5'h04, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 1'b0},// R8 upper counted
    {1'b0, 5'h01, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b1},// R7 unsigned word
    {1'b0, 5'h08, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0},// R7 -1 not > 0
    {1'b1, 5'h00, 64'h1, 64'h2, 1'b0},                                    // R9
    {1'b1, 5'h1F, 64'h9, 64'h9, 1'b1},                                    // R10
    {1'b0, 5'h1F, 64'hDEAD_0000_0000_0000, 64'h0, 1'b1},                  // R10 word mode
    {1'b1, 5'h18, 64'h9, 64'h9, 1'b0},                                    // R6 neither strict holds
    {1'b0, 5'h12, 64'h0000_0000_8000_0000, 64'h1, 1'b1}                   // R6 OR: s-lt true
  };

  function automatic string tag_for(input logic dw, input logic [4:0] m);
    if (m == 5'h00)      return "R9";
    else if (m == 5'h1F) return "R10";
    else if (!dw)        return "R7";
    else if (m == 5'h10) return "R1";
    else if (m == 5'h08) return "R2";
    else if (m == 5'h04) return "R3";
    else if (m == 5'h02) return "R4";
    else if (m == 5'h01) return "R5";
    else                 return "R6";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; dword_mode = 1'b1; cond_mask = 5'h00;
    op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 out_valid", {7'd0, out_valid}, 8'd0);
    check("R13 trap_req",  {7'd0, trap_req}, 8'd0);
    check("R13 trap_cause", {4'd0, trap_cause}, 8'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic dw; logic [4:0] m; logic exp_t;
      dw    = VEC[i][VW-1];
      m     = VEC[i][VW-2 -: 5];
      exp_t = VEC[i][0];
      @(negedge clk);
      in_valid = 1'b1; dword_mode = dw; cond_mask = m;
      op_a = VEC[i][2*DATA_W -: DATA_W];
      op_b = VEC[i][DATA_W -: DATA_W];
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 out_valid", {7'd0, out_valid}, 8'd1);
      check(tag_for(dw, m), {7'd0, trap_req}, {7'd0, exp_t});
      check("R12 cause", {4'd0, trap_cause}, exp_t ? 8'h02 : 8'h00);
    end

    // R11 idle cycle after a trapping request: outputs drop
    @(negedge clk);
    check("R11 idle out_valid", {7'd0, out_valid}, 8'd0);
    check("R11 idle trap_req",  {7'd0, trap_req}, 8'd0);
    check("R12 idle cause", {4'd0, trap_cause}, 8'd0);

    // R11 full mask with in_valid low still gives no trap
    cond_mask = 5'h1F; dword_mode = 1'b1; op_a = 64'h3; op_b = 64'h4;
    @(negedge clk);
    check("R11 no strobe", {7'd0, trap_req}, 8'd0);

    // R13 reset wins over a trapping request at the same edge
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R13 reset vs request valid", {7'd0, out_valid}, 8'd0);
    check("R13 reset vs request trap",  {7'd0, trap_req}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 after reset", {7'd0, trap_req}, 8'd1);

    // R11 back-to-back requests give one result each
    in_valid = 1'b1; cond_mask = 5'h00;
    @(negedge clk);
    check("R9 back-to-back", {7'd0, trap_req}, 8'd0);
    check("R11 back-to-back valid", {7'd0, out_valid}, 8'd1);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule